// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block finds divider settings for a clock synthesizer that produces a requested pixel clock. After a start pulse it takes the target frequency in kHz and walks through candidate post dividers P and input dividers N. For each pair it derives the smallest feedback divider M that reaches the target, then computes the output frequency `REF_KHZ*M/(N*P)`. The candidate with the smallest absolute error is kept.

The synthesizer does not take M and P directly. Each must split into two constrained sub-fields, M into M1/M2 and P into P1/P2. Any candidate whose M or P cannot be split is skipped. At the end the block pulses `done_o` and presents the split fields, N as `N-2`, and the achieved frequency. If no usable candidate was found it raises `fail_o` instead.

A single shared sequential restoring divider does every division: the two bounds of the P range, the ceiling for M, and the output frequency. Each candidate therefore costs a fixed two divisions. The reference clock, VCO limits, step-transition frequency and all divider bounds are parameters.

Top module: `pll_div_search`

## Requirements
- R1: After reset, `done_o` and `fail_o` are 0 and every result output (`m1_o`, `m2_o`, `n_code_o`, `p1_o`, `p2_o`, `freq_khz_o`) is 0.
- R2: `start_i` is only taken while the engine is idle. A start pulse during a running search is ignored, and the results that follow belong to the target captured at the first start.
- R3: The P step is 4 when the target is at or below `P_TRANS_KHZ`, and 2 above it. The sweep starts at `ceil(VCO_MIN_KHZ/target)` rounded up to a step multiple and raised to at least `P_MIN`. It ends at `floor(VCO_MAX_KHZ/target)` rounded down to a step multiple and capped at `P_MAX`. If the start exceeds the end, no P is tried.
- R4: P splits as follows. P2=1 if P mod 4 = 0, else P2=0. P1 = P/2^(P2+1) − 2. If P2=1 gives P1 < `P1_MIN`, retry with P2=0. P is skipped if P1 is outside `P1_MIN..P1_MAX` or (P1+2)·2^(P2+1) ≠ P. On output, `p2_o` is the single bit P2 and `p1_o` carries P1.
- R5: M = ceil(target·P·N/`REF_KHZ`), clamped to `M_MIN..M_MAX`. M1 = (M − 2 − (`M2_MIN`+`M2_MAX`)/2)/5 − 2 (integer division), clamped to `M1_MIN..M1_MAX`. M2 = M − 5·(M1+2) − 2. The candidate is skipped if M2 is outside its range or M2 ≥ M1.
- R6: For each accepted P, N starts at `N_MIN` and advances by 1. The loop continues while the next N is at most `N_MAX` and the current output frequency is still at or above the target. `n_code_o` carries N−2.
- R7: The best error starts at `ERR_INIT` (10,000,000). A candidate replaces the stored best only when its absolute error is strictly smaller, so among equal errors the first one found wins.
- R8: `freq_khz_o` is floor(`REF_KHZ`·M/(N·P)) for the chosen M, N and P.
- R9: If no candidate was stored, the engine ends with `fail_o`=1 and all field outputs and `freq_khz_o` at 0. A target of 0 or a target with an empty P range fails.
- R10: `done_o` is high for exactly one cycle per search. All result outputs change only in the cycle `done_o` rises and hold until the next completion.
- R11: A start pulse in the same cycle as `done_o` is accepted and launches a new search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a search (taken when idle) |
| target_khz_i | input | TGT_W | Target pixel clock in kHz |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | No valid divider set found |
| m1_o | output | M1_W | Feedback sub-divider M1 |
| m2_o | output | M2_W | Feedback sub-divider M2 |
| n_code_o | output | N_W | Input divider encoded as N−2 |
| p1_o | output | P1_W | Post sub-divider P1 |
| p2_o | output | 1 | Post sub-divider select P2 |
| freq_khz_o | output | 32 | Achieved output frequency in kHz |

## Verification
Two events can meet in one cycle: a search finishing and a new start arriving. This happens because `done_o` is raised in the first idle cycle. The bench provokes it by raising `start_i` in the cycle where it sees `done_o`. It then checks that the first result is intact and that the next completion carries the second target's result from an independent model. The bench also provokes the opposite case, a start arriving mid-search, and judges it by the later result matching the first target only.

// File: rtl/pll_search_pkg.sv
// Package: shared types for the PLL divider search engine.
// Assumes: all arithmetic inside the engine is carried in CALC_W bits.
package pll_search_pkg;
    localparam int CALC_W = 32;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DMAX,
        S_DMIN,
        S_PCHK,
        S_MDIV,
        S_FDIV,
        S_FIN
    } srch_state_t;
endpackage

// File: rtl/pll_seq_div.sv
// Module: restoring unsigned divider, one quotient bit per cycle.
// Assumes: go is a single-cycle pulse while idle; division by zero yields all ones.
module pll_seq_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]    rem_q;
    logic [W-1:0]  den_q;
    logic [CW-1:0] cnt_q;
    logic [W:0]    rem_sh;

    // Shift the next dividend bit into the partial remainder.
    always_comb rem_sh = {rem_q[W-1:0], quo[W-1]};

    // Load operands on go, then retire one quotient bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            quo   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                rem_q <= '0;
                den_q <= den;
                quo   <= num;
                cnt_q <= CW'(W);
            end else if (cnt_q != '0) begin
                if (rem_sh >= {1'b0, den_q}) begin
                    rem_q <= rem_sh - {1'b0, den_q};
                    quo   <= {quo[W-2:0], 1'b1};
                end else begin
                    rem_q <= rem_sh;
                    quo   <= {quo[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                done  <= (cnt_q == CW'(1));
            end
        end
    end
endmodule

// File: rtl/pll_m_split.sv
// Module: splits a feedback divider M into M1/M2 and flags unusable values.
// Assumes: m is already clamped to a positive range.
module pll_m_split #(
    parameter int M1_MIN = 10,
    parameter int M1_MAX = 20,
    parameter int M2_MIN = 5,
    parameter int M2_MAX = 9
) (
    input  logic [31:0] m,
    output logic [31:0] m1,
    output logic [31:0] m2,
    output logic        ok
);
    localparam int M2_MID = (M2_MIN + M2_MAX) / 2;

    int m1v;
    int m2v;

    // Derive M1 from M, clamp it, then derive M2 and judge the pair.
    always_comb begin
        m1v = (int'(m) - 2 - M2_MID) / 5 - 2;
        if (m1v < M1_MIN) m1v = M1_MIN;
        if (m1v > M1_MAX) m1v = M1_MAX;
        m2v = int'(m) - 5 * (m1v + 2) - 2;
        ok  = (m2v >= M2_MIN) && (m2v <= M2_MAX) && (m2v < m1v);
        m1  = 32'(m1v);
        m2  = 32'(m2v);
    end
endmodule

// File: rtl/pll_p_split.sv
// Module: splits a post divider P into P1/P2 and flags unusable values.
// Assumes: p is a positive even value.
module pll_p_split #(
    parameter int P1_MIN = 0,
    parameter int P1_MAX = 30
) (
    input  logic [31:0] p,
    output logic [31:0] p1,
    output logic        p2,
    output logic        ok
);
    int pv;
    int p1v;
    int p2v;

    // Prefer the divide-by-4 form, fall back to divide-by-2, then check.
    always_comb begin
        pv  = int'(p);
        p2v = (pv % 4 == 0) ? 1 : 0;
        p1v = pv / (2 << p2v) - 2;
        if (p2v == 1 && p1v < P1_MIN) begin
            p2v = 0;
            p1v = pv / 2 - 2;
        end
        ok = (p1v >= P1_MIN) && (p1v <= P1_MAX) && ((p1v + 2) * (2 << p2v) == pv);
        p1 = 32'(p1v);
        p2 = (p2v != 0);
    end
endmodule

// File: rtl/pll_div_search.sv
// Module: top of the PLL divider search engine.
// Sweeps P and N, derives M by ceiling division, scores each splittable
// candidate by absolute frequency error and reports the best one.
// Assumes: target_khz_i is stable only at the start pulse (it is captured).
module pll_div_search
    import pll_search_pkg::*;
#(
    parameter int TGT_W       = 20,
    parameter int REF_KHZ     = 48000,
    parameter int VCO_MIN_KHZ = 1400000,
    parameter int VCO_MAX_KHZ = 2800000,
    parameter int P_TRANS_KHZ = 200000,
    parameter int M_MIN       = 70,
    parameter int M_MAX       = 120,
    parameter int M1_MIN      = 10,
    parameter int M1_MAX      = 20,
    parameter int M2_MIN      = 5,
    parameter int M2_MAX      = 9,
    parameter int N_MIN       = 3,
    parameter int N_MAX       = 8,
    parameter int P_MIN       = 4,
    parameter int P_MAX       = 128,
    parameter int P1_MIN      = 0,
    parameter int P1_MAX      = 30,
    parameter int ERR_INIT    = 10000000,
    parameter int M1_W        = 6,
    parameter int M2_W        = 6,
    parameter int N_W         = 6,
    parameter int P1_W        = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TGT_W-1:0]  target_khz_i,
    output logic              done_o,
    output logic              fail_o,
    output logic [M1_W-1:0]   m1_o,
    output logic [M2_W-1:0]   m2_o,
    output logic [N_W-1:0]    n_code_o,
    output logic [P1_W-1:0]   p1_o,
    output logic              p2_o,
    output logic [31:0]       freq_khz_o
);
    localparam int DW = CALC_W;

    srch_state_t   state;
    logic [DW-1:0] tgt_q, p_cur, p_hi, n_cur, m_cur, best_err, best_f;
    logic [DW-1:0] div_num, div_den, div_quo;
    logic          div_go, div_done, found;
    logic [M1_W-1:0] best_m1;
    logic [M2_W-1:0] best_m2;
    logic [N_W-1:0]  best_nc;
    logic [P1_W-1:0] best_p1;
    logic            best_p2;

    logic [DW-1:0] inc_w, inc_mask, p_first, p_last, p_round, m_clamp, err_w;
    logic [DW-1:0] m1_w, m2_w, p1_w;
    logic          m_ok, p_ok, p2_w;

    pll_seq_div #(.W(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(div_den),
        .done(div_done), .quo(div_quo)
    );

    pll_m_split #(.M1_MIN(M1_MIN), .M1_MAX(M1_MAX), .M2_MIN(M2_MIN), .M2_MAX(M2_MAX)) u_msplit (
        .m(m_cur), .m1(m1_w), .m2(m2_w), .ok(m_ok)
    );

    pll_p_split #(.P1_MIN(P1_MIN), .P1_MAX(P1_MAX)) u_psplit (
        .p(p_cur), .p1(p1_w), .p2(p2_w), .ok(p_ok)
    );

    // Step size, range ends, M clamp and error for the current divider result.
    always_comb begin
        inc_w    = (tgt_q <= DW'(P_TRANS_KHZ)) ? DW'(4) : DW'(2);
        inc_mask = ~(inc_w - DW'(1));
        p_last   = ((div_quo & inc_mask) > DW'(P_MAX)) ? DW'(P_MAX) : (div_quo & inc_mask);
        p_round  = (div_quo + inc_w - DW'(1)) & inc_mask;
        if (div_quo > DW'(P_MAX))       p_first = DW'(P_MAX) + DW'(1);
        else if (p_round < DW'(P_MIN))  p_first = DW'(P_MIN);
        else                            p_first = p_round;
        if (div_quo < DW'(M_MIN))       m_clamp = DW'(M_MIN);
        else if (div_quo > DW'(M_MAX))  m_clamp = DW'(M_MAX);
        else                            m_clamp = div_quo;
        err_w = (tgt_q > div_quo) ? (tgt_q - div_quo) : (div_quo - tgt_q);
    end

    // Search sequencer: range setup, candidate loop, result hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            tgt_q    <= '0;
            p_cur    <= '0;
            p_hi     <= '0;
            n_cur    <= '0;
            m_cur    <= '0;
            best_err <= '0;
            best_f   <= '0;
            best_m1  <= '0;
            best_m2  <= '0;
            best_nc  <= '0;
            best_p1  <= '0;
            best_p2  <= 1'b0;
            found    <= 1'b0;
            div_go   <= 1'b0;
            div_num  <= '0;
            div_den  <= '0;
            done_o   <= 1'b0;
            fail_o   <= 1'b0;
            m1_o     <= '0;
            m2_o     <= '0;
            n_code_o <= '0;
            p1_o     <= '0;
            p2_o     <= 1'b0;
            freq_khz_o <= '0;
        end else begin
            div_go <= 1'b0;
            done_o <= 1'b0;
            unique case (state)
                S_IDLE: if (start_i) begin
                    tgt_q    <= DW'(target_khz_i);
                    best_err <= DW'(ERR_INIT);
                    best_f   <= '0;
                    best_m1  <= '0;
                    best_m2  <= '0;
                    best_nc  <= '0;
                    best_p1  <= '0;
                    best_p2  <= 1'b0;
                    found    <= 1'b0;
                    div_num  <= DW'(VCO_MAX_KHZ);
                    div_den  <= DW'(target_khz_i);
                    div_go   <= 1'b1;
                    state    <= S_DMAX;
                end
                S_DMAX: if (div_done) begin
                    p_hi    <= p_last;
                    div_num <= DW'(VCO_MIN_KHZ) + tgt_q - DW'(1);
                    div_den <= tgt_q;
                    div_go  <= 1'b1;
                    state   <= S_DMIN;
                end
                S_DMIN: if (div_done) begin
                    p_cur <= p_first;
                    state <= S_PCHK;
                end
                S_PCHK: begin
                    if (p_cur > p_hi) begin
                        state <= S_FIN;
                    end else if (!p_ok) begin
                        p_cur <= p_cur + inc_w;
                    end else begin
                        n_cur   <= DW'(N_MIN);
                        div_num <= tgt_q * p_cur * DW'(N_MIN) + DW'(REF_KHZ - 1);
                        div_den <= DW'(REF_KHZ);
                        div_go  <= 1'b1;
                        state   <= S_MDIV;
                    end
                end
                S_MDIV: if (div_done) begin
                    m_cur   <= m_clamp;
                    div_num <= DW'(REF_KHZ) * m_clamp;
                    div_den <= n_cur * p_cur;
                    div_go  <= 1'b1;
                    state   <= S_FDIV;
                end
                S_FDIV: if (div_done) begin
                    if (m_ok && err_w < best_err) begin
                        best_err <= err_w;
                        best_f   <= div_quo;
                        best_m1  <= M1_W'(m1_w);
                        best_m2  <= M2_W'(m2_w);
                        best_nc  <= N_W'(n_cur - DW'(2));
                        best_p1  <= P1_W'(p1_w);
                        best_p2  <= p2_w;
                        found    <= 1'b1;
                    end
                    if ((n_cur + DW'(1) <= DW'(N_MAX)) && (div_quo >= tgt_q)) begin
                        n_cur   <= n_cur + DW'(1);
                        div_num <= tgt_q * p_cur * (n_cur + DW'(1)) + DW'(REF_KHZ - 1);
                        div_den <= DW'(REF_KHZ);
                        div_go  <= 1'b1;
                        state   <= S_MDIV;
                    end else begin
                        p_cur <= p_cur + inc_w;
                        state <= S_PCHK;
                    end
                end
                S_FIN: begin
                    done_o     <= 1'b1;
                    fail_o     <= !found;
                    m1_o       <= best_m1;
                    m2_o       <= best_m2;
                    n_code_o   <= best_nc;
                    p1_o       <= best_p1;
                    p2_o       <= best_p2;
                    freq_khz_o <= best_f;
                    state      <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pll_div_search_chk.sv
// Module: property checker for the PLL divider search engine, bound to the top.
// Assumes: reset is held for at least two clock edges.
module pll_div_search_chk #(
    parameter int M1_W   = 6,
    parameter int M2_W   = 6,
    parameter int N_W    = 6,
    parameter int P1_W   = 5,
    parameter int N_MIN  = 3,
    parameter int N_MAX  = 8,
    parameter int M2_MIN = 5,
    parameter int M2_MAX = 9,
    parameter int P1_MAX = 30
) (
    input logic            clk,
    input logic            rst_n,
    input logic            done_o,
    input logic            fail_o,
    input logic [M1_W-1:0] m1_o,
    input logic [M2_W-1:0] m2_o,
    input logic [N_W-1:0]  n_code_o,
    input logic [P1_W-1:0] p1_o,
    input logic            p2_o,
    input logic [31:0]     freq_khz_o
);
    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: results only move together with the completion pulse
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(freq_khz_o) && $stable(fail_o) && $stable(m1_o) && $stable(n_code_o)));

    // R9: a failed search reports zero fields
    a_r9_fail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fail_o) |-> (freq_khz_o == 32'd0 && m1_o == '0 && m2_o == '0
                                && n_code_o == '0 && p1_o == '0 && !p2_o));

    // R6: reported N lies in its legal range
    a_r6_n_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fail_o) |-> ((32'(n_code_o) + 32'd2 >= 32'(N_MIN)) && (32'(n_code_o) + 32'd2 <= 32'(N_MAX))));

    // R5: reported M2 is in range and below M1
    a_r5_m_order: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fail_o) |-> ((32'(m2_o) < 32'(m1_o)) && (32'(m2_o) >= 32'(M2_MIN)) && (32'(m2_o) <= 32'(M2_MAX))));

    // R4: reported P1 is in range
    a_r4_p1_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fail_o) |-> (32'(p1_o) <= 32'(P1_MAX)));

    // R8: a successful search reports a nonzero frequency
    a_r8_freq_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fail_o) |-> (freq_khz_o != 32'd0));
endmodule

bind pll_div_search pll_div_search_chk #(
    .M1_W(M1_W), .M2_W(M2_W), .N_W(N_W), .P1_W(P1_W),
    .N_MIN(N_MIN), .N_MAX(N_MAX), .M2_MIN(M2_MIN), .M2_MAX(M2_MAX), .P1_MAX(P1_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .done_o(done_o), .fail_o(fail_o),
    .m1_o(m1_o), .m2_o(m2_o), .n_code_o(n_code_o), .p1_o(p1_o),
    .p2_o(p2_o), .freq_khz_o(freq_khz_o)
);

// File: tb/pll_div_search_bench.sv
// Bench: directed scenarios for the PLL divider search engine, checked
// against a behavioural model of the requirements.
module pll_div_search_bench;
    localparam int CLK_PERIOD = 10;
    localparam longint REF_KHZ = 48000, VCO_MIN = 1400000, VCO_MAX = 2800000, P_TRANS = 200000;
    localparam longint M_MIN = 70, M_MAX = 120, M1_MIN = 10, M1_MAX = 20, M2_MIN = 5, M2_MAX = 9;
    localparam longint N_MIN = 3, N_MAX = 8, P_MIN = 4, P_MAX = 128, P1_MIN = 0, P1_MAX = 30;
    localparam longint ERR_INIT = 10000000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [19:0] target_khz_i = '0;
    logic        done_o, fail_o, p2_o;
    logic [5:0]  m1_o, m2_o, n_code_o;
    logic [4:0]  p1_o;
    logic [31:0] freq_khz_o;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    pll_div_search u_pll_div_search (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .target_khz_i(target_khz_i),
        .done_o(done_o), .fail_o(fail_o), .m1_o(m1_o), .m2_o(m2_o),
        .n_code_o(n_code_o), .p1_o(p1_o), .p2_o(p2_o), .freq_khz_o(freq_khz_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit psplit(input longint p, output longint p1, output longint p2);
        p2 = (p % 4 == 0) ? 1 : 0;
        p1 = p / (2 << p2) - 2;
        if (p2 == 1 && p1 < P1_MIN) begin p2 = 0; p1 = p / 2 - 2; end
        return (p1 >= P1_MIN) && (p1 <= P1_MAX) && ((p1 + 2) * (2 << p2) == p);
    endfunction

    function automatic bit msplit(input longint m, output longint m1, output longint m2);
        m1 = (m - 2 - (M2_MIN + M2_MAX) / 2) / 5 - 2;
        if (m1 < M1_MIN) m1 = M1_MIN;
        if (m1 > M1_MAX) m1 = M1_MAX;
        m2 = m - 5 * (m1 + 2) - 2;
        return (m2 >= M2_MIN) && (m2 <= M2_MAX) && (m2 < m1);
    endfunction

    // Requirement model: R3..R9 evaluated directly in integers.
    task automatic model(input longint t, output bit fl, output longint m1, output longint m2,
                         output longint nc, output longint p1, output longint p2, output longint f);
        longint inc, pmin, pmax, dmin, best_err, bm, bn, bp, bf, m, fo, n, q1, q2;
        bit found;
        fl = 1; m1 = 0; m2 = 0; nc = 0; p1 = 0; p2 = 0; f = 0;
        if (t == 0) return;
        inc  = (t <= P_TRANS) ? 4 : 2;
        pmax = (VCO_MAX / t) / inc * inc;
        if (pmax > P_MAX) pmax = P_MAX;
        dmin = (VCO_MIN + t - 1) / t;
        if (dmin > P_MAX) pmin = P_MAX + 1;
        else begin
            pmin = (dmin + inc - 1) / inc * inc;
            if (pmin < P_MIN) pmin = P_MIN;
        end
        best_err = ERR_INIT; found = 0; bm = 0; bn = 0; bp = 0; bf = 0;
        for (longint p = pmin; p <= pmax; p += inc) begin
            if (!psplit(p, q1, q2)) continue;
            n = N_MIN;
            do begin
                m = (t * p * n + REF_KHZ - 1) / REF_KHZ;
                if (m < M_MIN) m = M_MIN;
                if (m > M_MAX) m = M_MAX;
                fo = REF_KHZ * m / (n * p);
                if (msplit(m, q1, q2)) begin
                    longint e = (t > fo) ? t - fo : fo - t;
                    if (e < best_err) begin
                        best_err = e; bm = m; bn = n; bp = p; bf = fo; found = 1;
                    end
                end
                n++;
            end while (n <= N_MAX && fo >= t);
        end
        if (!found) return;
        fl = 0;
        void'(msplit(bm, m1, m2));
        void'(psplit(bp, p1, p2));
        nc = bn - 2;
        f = bf;
    endtask

    task automatic pulse_start(input longint t);
        @(negedge clk);
        start_i = 1'b1;
        target_khz_i = 20'(t);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int cyc = 0;
        while (!done_o && cyc < 30000) begin
            @(negedge clk);
            cyc++;
        end
        chk(req, "done seen", longint'(done_o), 1);
    endtask

    task automatic compare(input longint t, input string tag);
        bit fl;
        longint m1, m2, nc, p1, p2, f;
        model(t, fl, m1, m2, nc, p1, p2, f);
        chk({tag, " R9"}, "fail", longint'(fail_o), longint'(fl));
        chk({tag, " R5"}, "m1", longint'(m1_o), m1);
        chk({tag, " R5"}, "m2", longint'(m2_o), m2);
        chk({tag, " R6"}, "n_code", longint'(n_code_o), nc);
        chk({tag, " R3/R4"}, "p1", longint'(p1_o), p1);
        chk({tag, " R4"}, "p2", longint'(p2_o), p2);
        chk({tag, " R7/R8"}, "freq", longint'(freq_khz_o), f);
    endtask

    // R1: reset values at the ports
    task automatic t_reset();
        chk("R1", "done", longint'(done_o), 0);
        chk("R1", "fail", longint'(fail_o), 0);
        chk("R1", "freq", longint'(freq_khz_o), 0);
        chk("R1", "fields", longint'({m1_o, m2_o, n_code_o, p1_o, p2_o}), 0);
    endtask

    // R3..R10: one plain search and its completion pulse
    task automatic t_search(input longint t, input string tag);
        pulse_start(t);
        wait_done(tag);
        compare(t, tag);
        @(negedge clk);
        chk({tag, " R10"}, "done one cycle", longint'(done_o), 0);
    endtask

    // R2: a start during a running search is ignored
    task automatic t_busy_start();
        pulse_start(108000);
        repeat (40) @(negedge clk);
        start_i = 1'b1;
        target_khz_i = 20'd250000;
        @(negedge clk);
        start_i = 1'b0;
        wait_done("R2");
        compare(108000, "R2");
        @(negedge clk);
        repeat (30) @(negedge clk);
        chk("R2", "no second done", longint'(done_o), 0);
    endtask

    // R11 and R10: start in the completion cycle, results held in between
    task automatic t_back_to_back();
        longint f_first;
        pulse_start(250000);
        wait_done("R11");
        compare(250000, "R11");
        f_first = longint'(freq_khz_o);
        start_i = 1'b1;
        target_khz_i = 20'd25175;
        @(negedge clk);
        start_i = 1'b0;
        chk("R10", "done dropped", longint'(done_o), 0);
        repeat (20) @(negedge clk);
        chk("R10", "freq held", longint'(freq_khz_o), f_first);
        wait_done("R11");
        compare(25175, "R11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_search(25175, "R3 low");
        t_search(200000, "R3 edge");
        t_search(200001, "R3 step2");
        t_search(12000, "R3 clamp");
        t_search(65000, "R7 mid");
        t_search(900000, "R9 empty");
        t_search(0, "R9 zero");
        t_busy_start();
        t_back_to_back();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (190000) @(negedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL R10 watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule